// File: doc/BRIEF.md
# Storage Reference and Change Recorder

This block tracks how real storage is used, one 2 KB block at a time. For every block it holds two flags. The reference flag records that the block was touched by any fetch or store. The change flag records that the block was written. A paging agent reads these flags to judge how active a page is, and whether a frame must be written back before it is given to another page.

Accesses arrive on one port as a real address plus a store qualifier. A command port carries three operations. A page-load clear wipes both flags of a page, and in 4 KB mode a page covers two blocks. A key-set operation clears only the change flag of one block. A read-and-reset operation returns the old flags of a block and clears only its reference flag. A separate sample port returns the flags of any block without changing them. Address translation, protection keys and the replacement policy are all outside this block.

Top module: `refchg_recorder`

## Requirements
- R1: After reset every reference and change flag reads 0 on the sample port, and cmd_done_o is 0.
- R2: An accepted access (acc_valid_i=1) sets the reference flag of its block at that clock edge.
- R3: An accepted store (acc_store_i=1) also sets the change flag. A fetch (acc_store_i=0) leaves the change flag unchanged.
- R4: Command code 2'b01 is the page-load clear. It clears both flags of the page. With page_4k_i=0 the page is the one addressed block. With page_4k_i=1 it is both blocks whose indices differ only in index bit 0 (address bit 11).
- R5: Command code 2'b10 is key-set. It clears the change flag of the addressed block only, and its reference flag is unchanged.
- R6: A change flag is never cleared by anything other than command codes 2'b01 and 2'b10.
- R7: If an access and a clearing command hit the same block in the same cycle, the flags the access sets end up set.
- R8: Command code 2'b11 is read-and-reset. In the next cycle cmd_done_o is 1 for one cycle, and cmd_ref_o and cmd_chg_o show the flags as they stood before the command. Only the reference flag is cleared.
- R9: The block index is address bits [ADDR_W-1:11]. Addresses 0x7FF and 0x800 fall in different blocks.
- R10: The sample port is registered. smp_ref_o and smp_chg_o show, one cycle later, the flags of the block in smp_addr_i as they stood before that cycle's updates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| acc_valid_i | input | 1 | Storage access accepted this cycle |
| acc_store_i | input | 1 | Access is a store (1) or a fetch (0) |
| acc_addr_i | input | ADDR_W | Real address of the access |
| cmd_op_i | input | 2 | 00 none, 01 page-load clear, 10 key-set, 11 read-and-reset |
| cmd_addr_i | input | ADDR_W | Real address the command targets |
| page_4k_i | input | 1 | Page size for the page-load clear: 1 = 4 KB, 0 = 2 KB |
| smp_addr_i | input | ADDR_W | Real address to sample |
| smp_ref_o | output | 1 | Sampled reference flag |
| smp_chg_o | output | 1 | Sampled change flag |
| cmd_done_o | output | 1 | Read-and-reset result is valid |
| cmd_ref_o | output | 1 | Reference flag before the read-and-reset |
| cmd_chg_o | output | 1 | Change flag before the read-and-reset |

## Verification
Accesses and commands update the flags at the edge where they are presented. The sample port registers the flags on the following edge, so a stimulus shows up on smp_ref_o and smp_chg_o two edges after it is driven. The read-and-reset result and cmd_done_o appear one edge after the command. The bench drives on falling edges. After each stimulus it holds one idle cycle with the sample address set, and reads on the next falling edge. For read-and-reset it reads the result one falling edge after the command.

// File: rtl/refchg_pkg.sv
package refchg_pkg;
  localparam int BLK_LSB = 11;

  typedef enum logic [1:0] {
    OP_NONE   = 2'b00,
    OP_LOAD   = 2'b01,
    OP_KEYSET = 2'b10,
    OP_RRR    = 2'b11
  } rc_op_e;
endpackage

// File: rtl/refchg_rst_sync.sv
module refchg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb sync_d = {sync_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/refchg_decode.sv
module refchg_decode #(
  parameter int ADDR_W = 20,
  parameter int BLK_W  = ADDR_W - refchg_pkg::BLK_LSB
) (
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [ADDR_W-1:0] smp_addr,
  output logic [BLK_W-1:0]  acc_idx,
  output logic [BLK_W-1:0]  cmd_idx,
  output logic [BLK_W-1:0]  smp_idx
);
  import refchg_pkg::*;

  always_comb begin
    acc_idx = acc_addr[ADDR_W-1:BLK_LSB];
    cmd_idx = cmd_addr[ADDR_W-1:BLK_LSB];
    smp_idx = smp_addr[ADDR_W-1:BLK_LSB];
  end
endmodule

// File: rtl/refchg_array.sv
module refchg_array #(
  parameter int BLK_W   = 9,
  parameter int NUM_BLK = 1 << BLK_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               acc_valid,
  input  logic               acc_store,
  input  logic [BLK_W-1:0]   acc_idx,
  input  logic [1:0]         cmd_op,
  input  logic [BLK_W-1:0]   cmd_idx,
  input  logic               page_4k,
  output logic [NUM_BLK-1:0] ref_q,
  output logic [NUM_BLK-1:0] chg_q
);
  import refchg_pkg::*;

  rc_op_e op;
  logic   op_load, op_key, op_rrr, upd_en;
  logic [NUM_BLK-1:0] ref_d, chg_d;

  always_comb begin
    op      = rc_op_e'(cmd_op);
    op_load = (op == OP_LOAD);
    op_key  = (op == OP_KEYSET);
    op_rrr  = (op == OP_RRR);
    upd_en  = acc_valid || (op != OP_NONE);
  end

  for (genvar g = 0; g < NUM_BLK; g++) begin : g_blk
    localparam logic [BLK_W-1:0] IDX = BLK_W'(g);
    logic hit_acc, hit_blk, hit_page, set_r, set_c, clr_r, clr_c;

    always_comb begin
      hit_acc  = acc_valid && (acc_idx == IDX);
      hit_blk  = (cmd_idx == IDX);
      hit_page = (cmd_idx[BLK_W-1:1] == IDX[BLK_W-1:1]) &&
                 (page_4k || (cmd_idx[0] == IDX[0]));
      set_r    = hit_acc;
      set_c    = hit_acc && acc_store;
      clr_r    = (op_load && hit_page) || (op_rrr && hit_blk);
      clr_c    = (op_load && hit_page) || (op_key && hit_blk);
      ref_d[g] = set_r || (ref_q[g] && !clr_r);
      chg_d[g] = set_c || (chg_q[g] && !clr_c);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q <= '0;
      chg_q <= '0;
    end else if (upd_en) begin
      ref_q <= ref_d;
      chg_q <= chg_d;
    end
  end
endmodule

// File: rtl/refchg_resp.sv
module refchg_resp #(
  parameter int BLK_W   = 9,
  parameter int NUM_BLK = 1 << BLK_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_BLK-1:0] ref_q,
  input  logic [NUM_BLK-1:0] chg_q,
  input  logic [BLK_W-1:0]   smp_idx,
  input  logic [1:0]         cmd_op,
  input  logic [BLK_W-1:0]   cmd_idx,
  output logic               smp_ref,
  output logic               smp_chg,
  output logic               cmd_done,
  output logic               cmd_ref,
  output logic               cmd_chg
);
  import refchg_pkg::*;

  logic smp_ref_d, smp_chg_d, done_d, cref_d, cchg_d, rrr_en;

  always_comb begin
    rrr_en    = (rc_op_e'(cmd_op) == OP_RRR);
    smp_ref_d = ref_q[smp_idx];
    smp_chg_d = chg_q[smp_idx];
    done_d    = rrr_en;
    cref_d    = ref_q[cmd_idx];
    cchg_d    = chg_q[cmd_idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_ref  <= 1'b0;
      smp_chg  <= 1'b0;
      cmd_done <= 1'b0;
    end else begin
      smp_ref  <= smp_ref_d;
      smp_chg  <= smp_chg_d;
      cmd_done <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_ref <= 1'b0;
      cmd_chg <= 1'b0;
    end else if (rrr_en) begin
      cmd_ref <= cref_d;
      cmd_chg <= cchg_d;
    end
  end
endmodule

// File: rtl/refchg_recorder.sv
module refchg_recorder #(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid_i,
  input  logic              acc_store_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic [1:0]        cmd_op_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic              page_4k_i,
  input  logic [ADDR_W-1:0] smp_addr_i,
  output logic              smp_ref_o,
  output logic              smp_chg_o,
  output logic              cmd_done_o,
  output logic              cmd_ref_o,
  output logic              cmd_chg_o
);
  localparam int BLK_W   = ADDR_W - refchg_pkg::BLK_LSB;
  localparam int NUM_BLK = 1 << BLK_W;

  logic               rst_sync_n;
  logic [BLK_W-1:0]   acc_idx, cmd_idx, smp_idx;
  logic [NUM_BLK-1:0] ref_q, chg_q;

  refchg_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  refchg_decode #(.ADDR_W(ADDR_W), .BLK_W(BLK_W)) u_dec (
    .acc_addr (acc_addr_i),
    .cmd_addr (cmd_addr_i),
    .smp_addr (smp_addr_i),
    .acc_idx  (acc_idx),
    .cmd_idx  (cmd_idx),
    .smp_idx  (smp_idx)
  );

  refchg_array #(.BLK_W(BLK_W), .NUM_BLK(NUM_BLK)) u_arr (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .acc_valid (acc_valid_i),
    .acc_store (acc_store_i),
    .acc_idx   (acc_idx),
    .cmd_op    (cmd_op_i),
    .cmd_idx   (cmd_idx),
    .page_4k   (page_4k_i),
    .ref_q     (ref_q),
    .chg_q     (chg_q)
  );

  refchg_resp #(.BLK_W(BLK_W), .NUM_BLK(NUM_BLK)) u_resp (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .ref_q    (ref_q),
    .chg_q    (chg_q),
    .smp_idx  (smp_idx),
    .cmd_op   (cmd_op_i),
    .cmd_idx  (cmd_idx),
    .smp_ref  (smp_ref_o),
    .smp_chg  (smp_chg_o),
    .cmd_done (cmd_done_o),
    .cmd_ref  (cmd_ref_o),
    .cmd_chg  (cmd_chg_o)
  );
endmodule

// File: rtl/refchg_checker.sv
module refchg_checker #(
  parameter int ADDR_W  = 20,
  parameter int BLK_W   = ADDR_W - 11,
  parameter int NUM_BLK = 1 << BLK_W
) (
  input logic               clk,
  input logic               rst_n,
  input logic               acc_valid,
  input logic               acc_store,
  input logic [ADDR_W-1:0]  acc_addr,
  input logic [1:0]         cmd_op,
  input logic [ADDR_W-1:0]  cmd_addr,
  input logic               page_4k,
  input logic               cmd_done,
  input logic [NUM_BLK-1:0] ref_q,
  input logic [NUM_BLK-1:0] chg_q
);
  logic [BLK_W-1:0] a_idx, c_idx;
  logic             lone_load;

  always_comb begin
    a_idx     = acc_addr[ADDR_W-1:11];
    c_idx     = cmd_addr[ADDR_W-1:11];
    lone_load = (cmd_op == 2'b01) && !acc_valid && !page_4k;
  end

  AST_ACC_SETS_REF: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> ref_q[$past(a_idx)]); // R2

  AST_STORE_SETS_CHG: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_store) |=> chg_q[$past(a_idx)]); // R3

  AST_LOAD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    lone_load |=> (!ref_q[$past(c_idx)] && !chg_q[$past(c_idx)])); // R4

  AST_CHG_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(chg_q) & ~chg_q)) |-> ($past(cmd_op) == 2'b01 || $past(cmd_op) == 2'b10)); // R6

  AST_RRR_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_op == 2'b11) |=> cmd_done); // R8

  AST_DONE_ONLY_RRR: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_op != 2'b11) |=> !cmd_done); // R8
endmodule

bind refchg_recorder refchg_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .acc_valid (acc_valid_i),
  .acc_store (acc_store_i),
  .acc_addr  (acc_addr_i),
  .cmd_op    (cmd_op_i),
  .cmd_addr  (cmd_addr_i),
  .page_4k   (page_4k_i),
  .cmd_done  (cmd_done_o),
  .ref_q     (ref_q),
  .chg_q     (chg_q)
);

// File: tb/refchg_recorder_tb_top.sv
module refchg_recorder_tb_top;
  localparam int ADDR_W = 20;
  localparam int BW     = ADDR_W - 11;

  logic clk = 1'b0;
  logic rst_n;
  logic acc_valid_i, acc_store_i, page_4k_i;
  logic [ADDR_W-1:0] acc_addr_i, cmd_addr_i, smp_addr_i;
  logic [1:0] cmd_op_i;
  logic smp_ref_o, smp_chg_o, cmd_done_o, cmd_ref_o, cmd_chg_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit ended  = 0;

  always #5 clk = ~clk;

  refchg_recorder #(.ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .acc_valid_i(acc_valid_i), .acc_store_i(acc_store_i), .acc_addr_i(acc_addr_i),
    .cmd_op_i(cmd_op_i), .cmd_addr_i(cmd_addr_i), .page_4k_i(page_4k_i),
    .smp_addr_i(smp_addr_i),
    .smp_ref_o(smp_ref_o), .smp_chg_o(smp_chg_o),
    .cmd_done_o(cmd_done_o), .cmd_ref_o(cmd_ref_o), .cmd_chg_o(cmd_chg_o)
  );

  typedef struct packed {
    logic          av;
    logic          st;
    logic [BW-1:0] ab;
    logic [1:0]    op;
    logic [BW-1:0] cb;
    logic          p4;
    logic [BW-1:0] kb;
    logic          er;
    logic          ec;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 1'b0, 9'd5,  2'b00, 9'd0,  1'b0, 9'd5,  1'b1, 1'b0}, // R2 R3 fetch
    '{1'b1, 1'b1, 9'd6,  2'b00, 9'd0,  1'b0, 9'd6,  1'b1, 1'b1}, // R3 store
    '{1'b1, 1'b0, 9'd7,  2'b00, 9'd0,  1'b0, 9'd7,  1'b1, 1'b0}, // R2
    '{1'b0, 1'b0, 9'd0,  2'b10, 9'd6,  1'b0, 9'd6,  1'b1, 1'b0}, // R5 key-set
    '{1'b1, 1'b1, 9'd6,  2'b01, 9'd6,  1'b0, 9'd6,  1'b1, 1'b1}, // R7 access wins
    '{1'b0, 1'b0, 9'd0,  2'b01, 9'd6,  1'b0, 9'd6,  1'b0, 1'b0}, // R4 2K clear
    '{1'b1, 1'b1, 9'd8,  2'b00, 9'd0,  1'b0, 9'd8,  1'b1, 1'b1}, // R3
    '{1'b1, 1'b1, 9'd9,  2'b00, 9'd0,  1'b0, 9'd9,  1'b1, 1'b1}, // R3
    '{1'b0, 1'b0, 9'd0,  2'b01, 9'd9,  1'b1, 9'd8,  1'b0, 1'b0}, // R4 4K pair
    '{1'b0, 1'b0, 9'd0,  2'b00, 9'd0,  1'b0, 9'd9,  1'b0, 1'b0}, // R4 4K pair
    '{1'b1, 1'b1, 9'd12, 2'b00, 9'd0,  1'b0, 9'd12, 1'b1, 1'b1}, // R3
    '{1'b1, 1'b1, 9'd13, 2'b00, 9'd0,  1'b0, 9'd13, 1'b1, 1'b1}, // R3
    '{1'b0, 1'b0, 9'd0,  2'b01, 9'd13, 1'b0, 9'd12, 1'b1, 1'b1}, // R4 2K spares neighbour
    '{1'b0, 1'b0, 9'd0,  2'b00, 9'd0,  1'b0, 9'd13, 1'b0, 1'b0}, // R4
    '{1'b0, 1'b0, 9'd0,  2'b00, 9'd0,  1'b0, 9'd7,  1'b1, 1'b0}  // R6 fetch-only block
  };

  task automatic check(input string req, input logic got, input logic exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  task automatic idle();
    acc_valid_i = 1'b0; acc_store_i = 1'b0; cmd_op_i = 2'b00; page_4k_i = 1'b0;
  endtask

  function automatic logic [ADDR_W-1:0] ba(input logic [BW-1:0] b, input logic [10:0] off);
    return {b, off};
  endfunction

  // drive one stimulus, then sample block kb two edges later
  task automatic step(input vec_t v, input string req);
    @(negedge clk);
    acc_valid_i = v.av; acc_store_i = v.st; acc_addr_i = ba(v.ab, 11'h3A5);
    cmd_op_i = v.op; cmd_addr_i = ba(v.cb, 11'h011); page_4k_i = v.p4;
    @(negedge clk);
    idle();
    smp_addr_i = ba(v.kb, 11'h7FF);
    @(negedge clk);
    check({req, " ref"}, smp_ref_o, v.er);
    check({req, " chg"}, smp_chg_o, v.ec);
  endtask

  task automatic sample(input logic [ADDR_W-1:0] a, input logic er, input logic ec, input string req);
    @(negedge clk);
    idle();
    smp_addr_i = a;
    @(negedge clk);
    check({req, " ref"}, smp_ref_o, er);
    check({req, " chg"}, smp_chg_o, ec);
  endtask

  task automatic rrr(input logic [BW-1:0] b, input logic av, input logic st,
                     input logic er, input logic ec, input string req);
    @(negedge clk);
    idle();
    cmd_op_i = 2'b11; cmd_addr_i = ba(b, 11'h100);
    acc_valid_i = av; acc_store_i = st; acc_addr_i = ba(b, 11'h200);
    @(negedge clk);
    idle();
    check({req, " done"}, cmd_done_o, 1'b1);
    check({req, " old ref"}, cmd_ref_o, er);
    check({req, " old chg"}, cmd_chg_o, ec);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    idle();
    acc_addr_i = '0; cmd_addr_i = '0; smp_addr_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    check("R1 done", cmd_done_o, 1'b0);
    sample(ba(9'd5, 11'h0), 1'b0, 1'b0, "R1 blk5");
    sample(ba(9'd300, 11'h0), 1'b0, 1'b0, "R1 blk300");

    for (int i = 0; i < NV; i++) step(VEC[i], "R2-table");

    // R8 read-and-reset
    rrr(9'd5, 1'b0, 1'b0, 1'b1, 1'b0, "R8 blk5");
    sample(ba(9'd5, 11'h0), 1'b0, 1'b0, "R8 after");
    step('{1'b1, 1'b1, 9'd20, 2'b00, 9'd0, 1'b0, 9'd20, 1'b1, 1'b1}, "R3 blk20");
    rrr(9'd20, 1'b0, 1'b0, 1'b1, 1'b1, "R8 blk20");
    sample(ba(9'd20, 11'h0), 1'b0, 1'b1, "R8 keeps chg");
    @(negedge clk);
    check("R8 one-cycle done", cmd_done_o, 1'b0);
    // R7 fetch in same cycle as read-and-reset
    rrr(9'd20, 1'b1, 1'b0, 1'b0, 1'b1, "R7 rrr+fetch");
    sample(ba(9'd20, 11'h0), 1'b1, 1'b1, "R7 fetch wins");

    // R9 block boundary
    @(negedge clk);
    acc_valid_i = 1'b1; acc_store_i = 1'b1; acc_addr_i = 20'h007FF;
    sample(20'h00000, 1'b1, 1'b1, "R9 blk0");
    sample(20'h00800, 1'b0, 1'b0, "R9 blk1");

    // R10 sample shows pre-update state
    @(negedge clk);
    idle();
    acc_valid_i = 1'b1; acc_addr_i = ba(9'd40, 11'h0); smp_addr_i = ba(9'd40, 11'h0);
    @(negedge clk);
    idle();
    check("R10 pre-update", smp_ref_o, 1'b0);
    @(negedge clk);
    check("R10 next", smp_ref_o, 1'b1);

    if (!ended) begin
      ended = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule